// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single 16-bit timer channel configured through one 16-bit mode register and one 16-bit data register. A 3-bit mode field chooses how the channel's counter behaves. Interval timing, event counting and single-shot delay count down from the data register. Free-running capture and single-shot capture count up from zero. A 2-bit edge field chooses which transitions of the external input are used. A clock-select field picks one of four prescaled clock enables, and a source bit can replace that enable with every clock. Mode encodings outside the five defined ones raise an error flag and stop all counting.

Software writes the data register (reload or capture value) and then the mode register. It then pulses the start input. Every mode register write stops the channel, so a new setup always begins from a start. The counter value can be read at any time, and the channel signals each completion on a one-cycle interrupt pulse.

Top module: `tmr_channel`

## Requirements
- R1: After reset the mode register reads 0000h (interval timer). Bits 13, 5 and 4 always read 0. With LINK_EN = 0, bit 11 reads 0 and writes to it are lost. All other bits read back as written. Address 00 is the mode register, 01 is the data register, 10 is the read-only counter, and 11 reads 0.
- R2: The mode field is bits 3:1: 000 interval, 010 capture, 011 event count, 100 one-count, 110 capture with one-count. Any other value sets mode_err. While mode_err is set the counter holds, start is ignored and no interrupt is raised.
- R3: In interval mode, start loads the counter from the data register. Each tick decrements it. At a tick with the counter at 0, irq pulses, tog_out inverts and the counter reloads, giving a period of data+1 ticks.
- R4: Bit 12 = 1 makes every clock a tick. With bit 12 = 0, the tick is pre_en[bits 15:14].
- R5: In event count mode (011), start loads the data register value. The counter decrements on each selected input edge and ignores ticks. irq pulses and tog_out inverts once every data+1 edges.
- R6: The edge field is bits 7:6. 00 selects falling edges, 01 rising edges, 10 both edges. evt_in passes through a two-stage synchronizer before edge detection.
- R7: In capture mode (010), start clears the counter, which counts up per tick. A selected edge copies the count into the data register, clears the counter and pulses irq. For edges D ticks apart the captured value is D-1.
- R8: When a capture and a bus write to the data register fall in the same cycle, the captured value is kept.
- R9: In one-count mode (100), a start while idle loads the data register. The counter decrements per tick. At 0 it pulses irq, inverts tog_out and stops. Starts that arrive while it is running are ignored, so irq appears data+1 ticks after the accepted start.
- R10: In capture with one-count mode (110), a start while idle clears the counter and it counts up. The first selected edge copies the count into the data register, pulses irq and stops the counter at that value. Later edges do nothing until the next start.
- R11: Edge field 11 treats a rising edge of evt_in as an extra start and a falling edge as the capture edge. In mode 110 a high pulse of W ticks therefore captures W-1.
- R12: Any write to the mode register stops the channel. The counter then holds and no further interrupts occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| pre_en | input | 4 | Prescaled clock enables, one chosen by bits 15:14 |
| start_trg | input | 1 | Start trigger |
| evt_in | input | 1 | External event / capture input (asynchronous) |
| irq | output | 1 | One-cycle interrupt pulse |
| tog_out | output | 1 | Inverts on each interrupt in down-counting modes |
| mode_err | output | 1 | Mode field holds a prohibited value |

## Verification
The data register has two writers: the bus and the capture path. Both can act on the same clock edge. The bench provokes the collision in capture mode by placing a data-register write exactly in the cycle where a synchronized falling edge of evt_in takes effect. The cycle is counted from the edge through the two synchronizer stages. The bench then reads the data register in the next cycle and expects the period-derived capture value rather than the written pattern.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_W    = 16;
    localparam int CKS_W    = 2;
    localparam int PRE_N    = 1 << CKS_W;
    localparam int ADDR_W   = 2;

    localparam logic [TMR_W-1:0] ZERO_MASK = 16'h2030;
    localparam logic [TMR_W-1:0] LINK_MASK = 16'h0800;

    typedef enum logic [2:0] {
        MD_INTERVAL = 3'b000,
        MD_CAPTURE  = 3'b010,
        MD_EVENT    = 3'b011,
        MD_ONECNT   = 3'b100,
        MD_CAPONE   = 3'b110
    } tmr_mode_e;

    typedef enum logic [1:0] {
        EDGE_FALL  = 2'b00,
        EDGE_RISE  = 2'b01,
        EDGE_BOTH  = 2'b10,
        EDGE_WIDTH = 2'b11
    } edge_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        AD_MODE = 2'b00,
        AD_DATA = 2'b01,
        AD_CNT  = 2'b10,
        AD_NONE = 2'b11
    } reg_addr_e;

    typedef struct packed {
        logic [CKS_W-1:0] clk_sel;   // 15:14
        logic             zero13;    // 13
        logic             fast_src;  // 12
        logic             link;      // 11
        logic [2:0]       spare;     // 10:8
        logic [1:0]       edge_sel;  // 7:6
        logic [1:0]       zero5_4;   // 5:4
        logic [2:0]       mode;      // 3:1
        logic             opt;       // 0
    } mode_reg_t;

    typedef struct packed {
        logic cap;
        logic start;
    } edge_evt_t;

    function automatic logic mode_legal(input logic [2:0] m);
        case (tmr_mode_e'(m))
            MD_INTERVAL, MD_CAPTURE, MD_EVENT, MD_ONECNT, MD_CAPONE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic mode_is_capture(input logic [2:0] m);
        return (tmr_mode_e'(m) == MD_CAPTURE) || (tmr_mode_e'(m) == MD_CAPONE);
    endfunction

endpackage

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg
    import tmr_pkg::*;
#(
    parameter bit LINK_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [TMR_W-1:0] wdata,
    output mode_reg_t        mode_q
);

    localparam logic [TMR_W-1:0] KEEP_MASK =
        LINK_EN ? ~ZERO_MASK : ~(ZERO_MASK | LINK_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr) begin
            mode_q <= mode_reg_t'(wdata & KEEP_MASK);
        end
    end

    // R2: the stored mode field follows the written value one cycle later
    a_r2_mode_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr |=> (mode_q.mode == $past(wdata[3:1])));

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      evt_in,
    input  logic [1:0] edge_sel,
    output edge_evt_t evt
);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              lvl;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], evt_in};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign lvl  = sync_q[SYNC_N-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        evt = '0;
        case (edge_sel_e'(edge_sel))
            EDGE_FALL:  evt.cap = fall;
            EDGE_RISE:  evt.cap = rise;
            EDGE_BOTH:  evt.cap = rise | fall;
            EDGE_WIDTH: begin
                evt.cap   = fall;
                evt.start = rise;
            end
            default: evt = '0;
        endcase
    end

    // R6: a single-direction edge never repeats on the next cycle
    a_r6_single_edge_pulse: assert property (@(posedge clk) disable iff (rst)
        (evt.cap && edge_sel != EDGE_BOTH) |=> (!evt.cap || edge_sel != $past(edge_sel)));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic             tick,
    input  edge_evt_t        evt,
    input  logic             start_trg,
    input  logic             mode_wr,
    input  logic             data_wr,
    input  logic [TMR_W-1:0] wdata,
    output logic [TMR_W-1:0] cnt_q,
    output logic [TMR_W-1:0] data_q,
    output logic             irq_q,
    output logic             tog_q,
    output logic             mode_err
);

    tmr_mode_e md;
    logic      legal;
    logic      start;
    logic      run_q;
    logic      cnt_zero;

    assign md       = tmr_mode_e'(mode);
    assign legal    = mode_legal(mode);
    assign mode_err = ~legal;
    assign start    = start_trg | evt.start;
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            data_q <= '0;
            run_q  <= 1'b0;
            irq_q  <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (data_wr) begin
                data_q <= wdata;
            end
            if (mode_wr) begin
                run_q <= 1'b0;
            end else if (legal) begin
                case (md)
                    MD_INTERVAL, MD_EVENT: begin
                        if (start) begin
                            cnt_q <= data_q;
                            run_q <= 1'b1;
                        end else if (run_q && ((md == MD_EVENT) ? evt.cap : tick)) begin
                            if (cnt_zero) begin
                                irq_q <= 1'b1;
                                tog_q <= ~tog_q;
                                cnt_q <= data_q;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    MD_ONECNT: begin
                        if (start && !run_q) begin
                            cnt_q <= data_q;
                            run_q <= 1'b1;
                        end else if (run_q && tick) begin
                            if (cnt_zero) begin
                                irq_q <= 1'b1;
                                tog_q <= ~tog_q;
                                run_q <= 1'b0;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    MD_CAPTURE: begin
                        if (start) begin
                            cnt_q <= '0;
                            run_q <= 1'b1;
                        end else if (run_q) begin
                            if (evt.cap) begin
                                data_q <= cnt_q;
                                cnt_q  <= '0;
                                irq_q  <= 1'b1;
                            end else if (tick) begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    MD_CAPONE: begin
                        if (start && !run_q) begin
                            cnt_q <= '0;
                            run_q <= 1'b1;
                        end else if (run_q) begin
                            if (evt.cap) begin
                                data_q <= cnt_q;
                                irq_q  <= 1'b1;
                                run_q  <= 1'b0;
                            end else if (tick) begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: run_q <= 1'b0;
                endcase
            end
        end
    end

    // R2: a prohibited mode freezes the counter
    a_r2_illegal_holds: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> $stable(cnt_q));

    // R3: interval mode steps down by one per tick while nonzero
    a_r3_down_step: assert property (@(posedge clk) disable iff (rst)
        (run_q && md == MD_INTERVAL && !mode_wr && !start && tick && !cnt_zero)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: capture mode steps up by one per tick without an edge
    a_r7_up_step: assert property (@(posedge clk) disable iff (rst)
        (run_q && md == MD_CAPTURE && !mode_wr && !start && !evt.cap && tick)
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8: capture takes precedence over a bus write of the data register
    a_r8_capture_wins: assert property (@(posedge clk) disable iff (rst)
        (run_q && mode_is_capture(mode) && !mode_wr && !start && evt.cap && data_wr)
        |=> (data_q == $past(cnt_q)));

    // R9: one-count expiry raises irq and stops the channel
    a_r9_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (run_q && md == MD_ONECNT && !mode_wr && tick && cnt_zero)
        |=> (irq_q && !run_q));

    // R12: a mode write leaves the channel idle
    a_r12_write_stops: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> !run_q);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter bit LINK_EN = 1'b0,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [TMR_W-1:0]  bus_wdata,
    output logic [TMR_W-1:0]  bus_rdata,
    input  logic [PRE_N-1:0]  pre_en,
    input  logic              start_trg,
    input  logic              evt_in,
    output logic              irq,
    output logic              tog_out,
    output logic              mode_err
);

    mode_reg_t        mode_q;
    edge_evt_t        evt;
    logic             mode_wr;
    logic             data_wr;
    logic             tick;
    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] data_q;

    assign mode_wr = bus_wr && (reg_addr_e'(bus_addr) == AD_MODE);
    assign data_wr = bus_wr && (reg_addr_e'(bus_addr) == AD_DATA);
    assign tick    = mode_q.fast_src | pre_en[mode_q.clk_sel];

    tmr_mode_reg #(.LINK_EN(LINK_EN)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr     (mode_wr),
        .wdata  (bus_wdata),
        .mode_q (mode_q)
    );

    tmr_edge_det #(.SYNC_N(SYNC_N)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .evt_in   (evt_in),
        .edge_sel (mode_q.edge_sel),
        .evt      (evt)
    );

    tmr_core u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q.mode),
        .tick      (tick),
        .evt       (evt),
        .start_trg (start_trg),
        .mode_wr   (mode_wr),
        .data_wr   (data_wr),
        .wdata     (bus_wdata),
        .cnt_q     (cnt_q),
        .data_q    (data_q),
        .irq_q     (irq),
        .tog_q     (tog_out),
        .mode_err  (mode_err)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            AD_MODE: bus_rdata = mode_q;
            AD_DATA: bus_rdata = data_q;
            AD_CNT:  bus_rdata = cnt_q;
            default: bus_rdata = '0;
        endcase
    end

    // R1: reserved bits of the mode register never read as one
    a_r1_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_e'(bus_addr) == AD_MODE) |-> ((bus_rdata & ZERO_MASK) == '0));

    // R2: no interrupt while a prohibited mode is held
    a_r2_no_irq_illegal: assert property (@(posedge clk) disable iff (rst)
        (mode_err && $past(mode_err)) |-> !irq);

endmodule

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  pre_en = '0;
    logic        start_trg = 1'b0;
    logic        evt_in = 1'b0;
    logic        irq;
    logic        tog_out;
    logic        mode_err;

    int n_vec  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int ref_cyc = 0;
    int edge_cnt = 0;
    int mon_kind = 0;
    bit done = 1'b0;
    int exp_q[$];
    string req_q[$];
    int meas;
    int e_val;
    string e_req;

    always #2 clk = ~clk;   // 250 MHz

    tmr_channel u_tmr_channel (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pre_en(pre_en),
        .start_trg(start_trg), .evt_in(evt_in), .irq(irq),
        .tog_out(tog_out), .mode_err(mode_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input int act, input int exp, input string req);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_irq(input int v, input string req);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    // monitor: pops one expectation per interrupt pulse
    always @(negedge clk) begin
        if (!rst && irq) begin
            meas = (mon_kind == 1) ? edge_cnt : (cyc - ref_cyc);
            ref_cyc = cyc;
            edge_cnt = 0;
            if (exp_q.size() == 0) begin
                n_vec++;
                n_fail++;
                $display("FAIL unexpected irq (R2/R9/R10/R12): actual 1 expected 0");
            end else begin
                e_val = exp_q.pop_front();
                e_req = req_q.pop_front();
                if (e_val >= 0) check(meas, e_val, e_req);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse_start();
        start_trg = 1'b1;
        ref_cyc = cyc;
        edge_cnt = 0;
        @(negedge clk);
        start_trg = 1'b0;
    endtask

    task automatic evt_pulse(input int hi, input int lo, input bit cnt_r, input bit cnt_f);
        evt_in = 1'b1;
        if (cnt_r) edge_cnt++;
        repeat (hi) @(negedge clk);
        evt_in = 1'b0;
        if (cnt_f) edge_cnt++;
        repeat (lo) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int v2;
        int t0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'b00, v); check(v, 16'h0000, "R1 reset mode");
        check(mode_err, 0, "R2 reset legal");
        check(irq, 0, "R1 reset irq");
        check(tog_out, 0, "R1 reset tog");

        // R1 masked read-back, R2 illegal flag
        wr(2'b00, 16'hFFFF);
        rd(2'b00, v); check(v, 16'hD7CF, "R1 zero bits");
        check(mode_err, 1, "R2 mode 111 flagged");
        wr(2'b10, 16'h1234);
        rd(2'b10, v); check(v, 0, "R1 counter not writable");

        // R2 prohibited mode 001 never counts
        wr(2'b01, 16'd5);
        wr(2'b00, 16'h1002);
        check(mode_err, 1, "R2 mode 001 flagged");
        pulse_start();
        idle(20);
        rd(2'b10, v); check(v, 0, "R2 counter held");

        // R3 interval mode with every-clock ticks (R4 bit 12)
        wr(2'b01, 16'd4);
        wr(2'b00, 16'h1000);
        check(mode_err, 0, "R2 interval legal");
        mon_kind = 0;
        expect_irq(6, "R3 first interval");
        expect_irq(5, "R3 reload period");
        expect_irq(5, "R3 reload period");
        pulse_start();
        idle(17);
        wr(2'b00, 16'h1000);
        check(exp_q.size(), 0, "R3 three interrupts seen");
        check(tog_out, 1, "R3 toggle count");
        // R12 stopped channel stays quiet and frozen
        rd(2'b10, v);
        idle(10);
        rd(2'b10, v2); check(v2, v, "R12 counter frozen");

        // R4 clock select picks pre_en[1]
        wr(2'b01, 16'd2);
        wr(2'b00, 16'h4000);
        fork
            begin
                repeat (40) begin
                    pre_en = {2'b00, ~pre_en[1], 1'b1};
                    @(negedge clk);
                end
                pre_en = '0;
            end
            begin
                expect_irq(-1, "R4 first");
                expect_irq(6, "R4 divided period");
                expect_irq(6, "R4 divided period");
                pulse_start();
                idle(19);
                wr(2'b00, 16'h4000);
                check(exp_q.size(), 0, "R4 interrupts seen");
            end
        join

        // R5/R6 event count on rising edges
        wr(2'b01, 16'd2);
        wr(2'b00, 16'h1046);
        mon_kind = 1;
        pulse_start();
        expect_irq(3, "R5 edges per irq");
        expect_irq(3, "R5 edges per irq");
        expect_irq(3, "R5 edges per irq");
        for (int i = 0; i < 9; i++) evt_pulse(4, 4, 1, 0);
        idle(4);
        check(exp_q.size(), 0, "R5 rising count");

        // R6 both edges
        wr(2'b01, 16'd3);
        wr(2'b00, 16'h1086);
        pulse_start();
        expect_irq(4, "R6 both edges");
        expect_irq(4, "R6 both edges");
        for (int i = 0; i < 4; i++) evt_pulse(4, 4, 1, 1);
        idle(4);
        check(exp_q.size(), 0, "R6 both-edge count");
        wr(2'b00, 16'h1086);
        mon_kind = 0;

        // R7 capture on falling edges, period 10
        wr(2'b00, 16'h1004);
        pulse_start();
        expect_irq(-1, "R7 first capture");
        expect_irq(10, "R7 capture spacing");
        expect_irq(10, "R7 capture spacing");
        for (int i = 0; i < 3; i++) evt_pulse(5, 5, 0, 0);
        rd(2'b01, v); check(v, 9, "R7 captured period");

        // R8 capture and data write in the same cycle
        expect_irq(10, "R8 capture spacing");
        evt_in = 1'b1;
        idle(5);
        evt_in = 1'b0;
        idle(2);
        wr(2'b01, 16'hABCD);
        rd(2'b01, v); check(v, 9, "R8 capture beats write");
        idle(3);
        wr(2'b00, 16'h1004);
        check(exp_q.size(), 0, "R8 irq seen");

        // R9 one-count, retrigger ignored
        wr(2'b01, 16'd6);
        wr(2'b00, 16'h1008);
        v2 = tog_out;
        expect_irq(8, "R9 delay from start");
        pulse_start();
        idle(2);
        start_trg = 1'b1; @(negedge clk); start_trg = 1'b0;
        idle(15);
        check(exp_q.size(), 0, "R9 single irq");
        check(tog_out, v2 ^ 1, "R9 one toggle");
        rd(2'b10, v); check(v, 0, "R9 stopped at zero");
        expect_irq(8, "R9 rearmed");
        pulse_start();
        idle(12);
        check(exp_q.size(), 0, "R9 second shot");

        // R10 capture with one-count
        wr(2'b00, 16'h100C);
        expect_irq(-1, "R10 single capture");
        pulse_start();
        idle(6);
        evt_pulse(5, 5, 0, 0);
        rd(2'b01, v); rd(2'b10, v2);
        check(v2, v, "R10 count held at capture");
        evt_pulse(5, 5, 0, 0);
        rd(2'b10, v); check(v, v2, "R10 later edge ignored");
        check(exp_q.size(), 0, "R10 irq seen");

        // R11 width measurement via edge field 11
        wr(2'b00, 16'h10CC);
        expect_irq(-1, "R11 width irq");
        evt_pulse(7, 6, 0, 0);
        rd(2'b01, v); check(v, 6, "R11 width 7");
        expect_irq(-1, "R11 width irq");
        evt_pulse(12, 6, 0, 0);
        rd(2'b01, v); check(v, 11, "R11 width 12");
        check(exp_q.size(), 0, "R11 irqs seen");

        t0 = cyc;
        idle(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule